// File: doc/BRIEF.md
# Pixel Clock Divisor Calculator

This block turns a requested pixel clock, given in kHz, into the settings of a phase-interpolator clock synthesizer. The synthesizer divides a fixed root of 172,800,000 (kHz-scaled units). Its divisor is split into an integer divider select, with an offset of two, and a phase increment in steps of 1/64. A post-divider that halves the output can be switched in. When the divider select would not fit its 7-bit field, the block retries once with the post-divider switched in. It then rebuilds the frequency that the chosen settings really produce and flags any difference from the request.

A second mode runs the rebuild alone. Software that finds the synthesizer already programmed passes the three fields in, and the block returns the achieved frequency. Both modes use one shared sequential divider that produces one quotient bit per cycle. A calculation therefore takes a few tens to about a hundred cycles. The caller pulses `start_i`, waits for the one-cycle `done_o` pulse and reads the registered results. These hold until the next calculation finishes.

Top module: `pclk_div_calc`

## Requirements
- R1: While reset is high, and until the first calculation ends, `done_o`, `busy_o`, every field output, `freq_khz_o`, `mismatch_o` and `range_err_o` are all zero.
- R2: In compute mode (`mode_i`=0), the total divisor is D = floor((172800000 + den/2) / den), where den = request << aux. Then `divsel_o` = D/64 - 2 and `phinc_o` = D mod 64.
- R3: The first attempt uses aux = 0. It is accepted when D/64 - 2 lies in 0..127, that is when 128 <= D <= 8319, and then `aux_o` = 0.
- R4: If the first attempt is out of range, the block repeats the calculation once with aux = 1 and reports `aux_o` = 1 when that attempt fits. It never tries a larger post-divide.
- R5: A request of zero, or a second attempt that is still out of range, sets `range_err_o` = 1 with `divsel_o`, `phinc_o`, `aux_o`, `freq_khz_o` and `mismatch_o` all zero.
- R6: `phdir_o`, the phase direction, is always 0.
- R7: In compute mode without a range error, `freq_khz_o` = floor((172800000 + E/2) / E), where E = D << aux. `mismatch_o` is 1 exactly when this value differs from the request.
- R8: In reconstruct mode (`mode_i`=1), D = (`set_divsel_i` + 2)*64 + `set_phinc_i` and aux = `set_aux_i`. The fields are echoed, `freq_khz_o` follows the R7 formula, and `mismatch_o` and `range_err_o` are 0.
- R9: `done_o` is high for exactly one cycle per accepted start. `busy_o` is high from the cycle after an accepted start until `done_o`. A start while busy is ignored. Outputs change only in the cycle `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken when not busy |
| mode_i | input | 1 | 0 = compute settings, 1 = reconstruct frequency |
| req_khz_i | input | 32 | Requested pixel clock in kHz (compute mode) |
| set_divsel_i | input | 7 | Divider select to rebuild from (reconstruct mode) |
| set_phinc_i | input | 6 | Phase increment to rebuild from (reconstruct mode) |
| set_aux_i | input | 1 | Post-divide-by-two select to rebuild from |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Calculation in progress |
| divsel_o | output | 7 | Integer divider select |
| phinc_o | output | 6 | Phase increment in 1/64 steps |
| aux_o | output | 1 | Post-divide-by-two select |
| phdir_o | output | 1 | Phase direction, always 0 |
| freq_khz_o | output | 32 | Achieved frequency in kHz |
| mismatch_o | output | 1 | Achieved frequency differs from request |
| range_err_o | output | 1 | No setting fits the divider field |

## Verification
The hardest paths to reach are the edges of the divider-select window. These are the requests whose first divisor lands just above 8319 or below 128, so the retry runs and then either fits or fails. The stimulus picks requests on both sides of these edges. Examples are 21000 kHz (fits at aux 0, select 126) and 20700 kHz (select 128, retried), plus a request near 20 MHz that rebuilds exactly. It also pulses start in the middle of a calculation and checks that the result still belongs to the first request.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  localparam int unsigned DEF_CLK_W    = 32;
  localparam int unsigned DEF_ROOT_KHZ = 172800000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD_GO,
    ST_FWD_WAIT,
    ST_CHECK,
    ST_REV_GO,
    ST_REV_WAIT,
    ST_FIN
  } calc_state_e;

endpackage

// File: rtl/pclk_seq_divider.sv
// Restoring divider: one quotient bit per cycle, W cycles per division.
module pclk_seq_divider #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     dvd_q;
  logic [W-1:0]     dvs_q;
  logic [W:0]       rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial;
  logic             take;

  always_comb begin
    trial = {rem_q[W-1:0], dvd_q[W-1]};
    take  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      quo_o  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        dvd_q  <= num_i;
        dvs_q  <= den_i;
        rem_q  <= '0;
        quo_o  <= '0;
        cnt_q  <= CNT_W'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        dvd_q <= {dvd_q[W-2:0], 1'b0};
        if (take) begin
          rem_q <= trial - {1'b0, dvs_q};
          quo_o <= {quo_o[W-2:0], 1'b1};
        end else begin
          rem_q <= trial;
          quo_o <= {quo_o[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pclk_field_codec.sv
// Splits a total divisor into select/phase fields and joins fields back.
module pclk_field_codec #(
  parameter int unsigned DW         = 34,
  parameter int unsigned SEL_W      = 7,
  parameter int unsigned PH_W       = 6,
  parameter int unsigned SEL_OFFSET = 2
) (
  input  logic [DW-1:0]    divisor_i,
  output logic [SEL_W-1:0] split_sel_o,
  output logic [PH_W-1:0]  split_ph_o,
  output logic             split_ok_o,
  input  logic [SEL_W-1:0] join_sel_i,
  input  logic [PH_W-1:0]  join_ph_i,
  output logic [DW-1:0]    join_div_o
);
  localparam logic [DW-1:0] OFS    = DW'(SEL_OFFSET);
  localparam logic [DW-1:0] SEL_MX = DW'((1 << SEL_W) - 1);

  logic [DW-1:0] coarse;
  logic [DW-1:0] shifted;

  always_comb begin
    coarse      = divisor_i >> PH_W;
    shifted     = coarse - OFS;
    split_ok_o  = (coarse >= OFS) && (shifted <= SEL_MX);
    split_sel_o = shifted[SEL_W-1:0];
    split_ph_o  = divisor_i[PH_W-1:0];
    join_div_o  = ((DW'(join_sel_i) + OFS) << PH_W) | DW'(join_ph_i);
  end
endmodule

// File: rtl/pclk_div_calc.sv
module pclk_div_calc
  import pclk_div_pkg::*;
#(
  parameter int unsigned CLK_W      = DEF_CLK_W,
  parameter int unsigned ROOT_KHZ   = DEF_ROOT_KHZ,
  parameter int unsigned PI_RANGE   = 64,
  parameter int unsigned SEL_W      = 7,
  parameter int unsigned SEL_OFFSET = 2,
  localparam int unsigned PH_W      = $clog2(PI_RANGE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CLK_W-1:0] req_khz_i,
  input  logic [SEL_W-1:0] set_divsel_i,
  input  logic [PH_W-1:0]  set_phinc_i,
  input  logic             set_aux_i,
  output logic             done_o,
  output logic             busy_o,
  output logic [SEL_W-1:0] divsel_o,
  output logic [PH_W-1:0]  phinc_o,
  output logic             aux_o,
  output logic             phdir_o,
  output logic [CLK_W-1:0] freq_khz_o,
  output logic             mismatch_o,
  output logic             range_err_o
);
  localparam int unsigned   DW   = CLK_W + 2;
  localparam logic [DW-1:0] ROOT = DW'(ROOT_KHZ);

  calc_state_e      state_q;
  logic [CLK_W-1:0] req_q;
  logic             mode_q;
  logic             aux_q;
  logic             err_q;
  logic [DW-1:0]    divisor_q;
  logic [SEL_W-1:0] sel_q;
  logic [PH_W-1:0]  ph_q;
  logic [CLK_W-1:0] freq_q;

  logic [DW-1:0]    den_c;
  logic [DW-1:0]    num_c;
  logic             div_start;
  logic             div_busy;
  logic             div_done;
  logic [DW-1:0]    div_quo;
  logic [SEL_W-1:0] fwd_sel;
  logic [PH_W-1:0]  fwd_ph;
  logic             fwd_ok;
  logic [DW-1:0]    join_div;

  // One divider serves both directions; the state picks the denominator.
  always_comb begin
    if (state_q == ST_REV_GO) den_c = divisor_q << aux_q;
    else                      den_c = DW'(req_q) << aux_q;
    num_c     = ROOT + (den_c >> 1);
    div_start = (state_q == ST_FWD_GO) || (state_q == ST_REV_GO);
  end

  pclk_seq_divider #(.W(DW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_start),
    .num_i   (num_c),
    .den_i   (den_c),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  pclk_field_codec #(
    .DW(DW), .SEL_W(SEL_W), .PH_W(PH_W), .SEL_OFFSET(SEL_OFFSET)
  ) u_codec (
    .divisor_i   (divisor_q),
    .split_sel_o (fwd_sel),
    .split_ph_o  (fwd_ph),
    .split_ok_o  (fwd_ok),
    .join_sel_i  (set_divsel_i),
    .join_ph_i   (set_phinc_i),
    .join_div_o  (join_div)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign phdir_o = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      mode_q      <= 1'b0;
      aux_q       <= 1'b0;
      err_q       <= 1'b0;
      divisor_q   <= '0;
      sel_q       <= '0;
      ph_q        <= '0;
      freq_q      <= '0;
      done_o      <= 1'b0;
      divsel_o    <= '0;
      phinc_o     <= '0;
      aux_o       <= 1'b0;
      freq_khz_o  <= '0;
      mismatch_o  <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            req_q  <= req_khz_i;
            mode_q <= mode_i;
            err_q  <= 1'b0;
            freq_q <= '0;
            if (mode_i) begin
              aux_q     <= set_aux_i;
              sel_q     <= set_divsel_i;
              ph_q      <= set_phinc_i;
              divisor_q <= join_div;
              state_q   <= ST_REV_GO;
            end else begin
              aux_q <= 1'b0;
              if (req_khz_i == '0) begin
                err_q   <= 1'b1;
                state_q <= ST_FIN;
              end else begin
                state_q <= ST_FWD_GO;
              end
            end
          end
        end
        ST_FWD_GO: state_q <= ST_FWD_WAIT;
        ST_FWD_WAIT: begin
          if (div_done) begin
            divisor_q <= div_quo;
            state_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fwd_ok) begin
            sel_q   <= fwd_sel;
            ph_q    <= fwd_ph;
            state_q <= ST_REV_GO;
          end else if (!aux_q) begin
            aux_q   <= 1'b1;
            state_q <= ST_FWD_GO;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        ST_REV_GO: state_q <= ST_REV_WAIT;
        ST_REV_WAIT: begin
          if (div_done) begin
            freq_q  <= div_quo[CLK_W-1:0];
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
          if (err_q) begin
            divsel_o    <= '0;
            phinc_o     <= '0;
            aux_o       <= 1'b0;
            freq_khz_o  <= '0;
            mismatch_o  <= 1'b0;
            range_err_o <= 1'b1;
          end else begin
            divsel_o    <= sel_q;
            phinc_o     <= ph_q;
            aux_o       <= aux_q;
            freq_khz_o  <= freq_q;
            mismatch_o  <= !mode_q && (freq_q != req_q);
            range_err_o <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pclk_div_calc_chk.sv
module pclk_div_calc_chk #(
  parameter int unsigned CLK_W = 32,
  parameter int unsigned SEL_W = 7,
  parameter int unsigned PH_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             done_o,
  input logic             busy_o,
  input logic [SEL_W-1:0] divsel_o,
  input logic [PH_W-1:0]  phinc_o,
  input logic             aux_o,
  input logic [CLK_W-1:0] freq_khz_o,
  input logic             mismatch_o,
  input logic             range_err_o
);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: the block is idle when it reports completion
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R9: an accepted start makes the block busy
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R9: results move only together with the completion pulse
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(freq_khz_o) && $stable(divsel_o) && $stable(phinc_o)
                 && $stable(aux_o) && $stable(mismatch_o) && $stable(range_err_o)));

  // R5: a range error carries cleared fields and no mismatch
  a_r5_err_clean: assert property (@(posedge clk) disable iff (rst)
    range_err_o |-> (divsel_o == '0 && phinc_o == '0 && !aux_o
                     && freq_khz_o == '0 && !mismatch_o));
endmodule

bind pclk_div_calc pclk_div_calc_chk #(
  .CLK_W(CLK_W), .SEL_W(SEL_W), .PH_W(PH_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .divsel_o    (divsel_o),
  .phinc_o     (phinc_o),
  .aux_o       (aux_o),
  .freq_khz_o  (freq_khz_o),
  .mismatch_o  (mismatch_o),
  .range_err_o (range_err_o)
);

// File: tb/pclk_div_calc_tb_top.sv
module pclk_div_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint ROOT   = 172800000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] req_khz_i = '0;
  logic [6:0]  set_divsel_i = '0;
  logic [5:0]  set_phinc_i = '0;
  logic        set_aux_i = 1'b0;
  logic        done_o, busy_o, aux_o, phdir_o, mismatch_o, range_err_o;
  logic [6:0]  divsel_o;
  logic [5:0]  phinc_o;
  logic [31:0] freq_khz_o;

  int n_total = 0;
  int n_bad   = 0;
  int cyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_div_calc dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .req_khz_i(req_khz_i), .set_divsel_i(set_divsel_i),
    .set_phinc_i(set_phinc_i), .set_aux_i(set_aux_i),
    .done_o(done_o), .busy_o(busy_o), .divsel_o(divsel_o),
    .phinc_o(phinc_o), .aux_o(aux_o), .phdir_o(phdir_o),
    .freq_khz_o(freq_khz_o), .mismatch_o(mismatch_o),
    .range_err_o(range_err_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference of the settings and achieved frequency.
  task automatic model(input bit md, input longint req, input int s_in,
                       input int p_in, input int a_in,
                       output int e_sel, output int e_ph, output int e_aux,
                       output longint e_freq, output int e_mis, output int e_err);
    longint d, den, e;
    bit found;
    e_sel = 0; e_ph = 0; e_aux = 0; e_freq = 0; e_mis = 0; e_err = 0;
    found = 0; d = 0;
    if (md) begin
      d = (s_in + 2) * 64 + p_in;
      e_sel = s_in; e_ph = p_in; e_aux = a_in; found = 1;
    end else if (req != 0) begin
      for (int a = 0; a < 2 && !found; a++) begin
        den = req << a;
        d = (ROOT + den / 2) / den;
        if (d / 64 >= 2 && d / 64 - 2 <= 127) begin
          found = 1; e_aux = a; e_sel = int'(d / 64 - 2); e_ph = int'(d % 64);
        end
      end
    end
    if (!found) begin
      e_err = 1;
    end else begin
      e = d << e_aux;
      e_freq = (ROOT + e / 2) / e;
      e_mis = (!md && e_freq != req) ? 1 : 0;
    end
  endtask

  // Every-cycle monitor: pulse width, hold between completions, watchdog.
  logic [6:0]  p_sel;
  logic [5:0]  p_ph;
  logic [31:0] p_freq;
  logic        p_aux, p_mis, p_err, p_done;
  bit          armed = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(0, "R9", "watchdog expired", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
    if (!rst) begin
      if (armed) begin
        if (done_o) check(!p_done, "R9", "done wider than one cycle", 1, 0);
        else if ({divsel_o, phinc_o, aux_o, freq_khz_o, mismatch_o, range_err_o} !=
                 {p_sel, p_ph, p_aux, p_freq, p_mis, p_err})
          check(0, "R9", "outputs moved without done", freq_khz_o, p_freq);
        if (phdir_o !== 1'b0) check(0, "R6", "phase direction", phdir_o, 0);
      end
      armed = 1;
    end
    p_sel = divsel_o; p_ph = phinc_o; p_aux = aux_o; p_freq = freq_khz_o;
    p_mis = mismatch_o; p_err = range_err_o; p_done = done_o;
  end

  task automatic run_op(input bit md, input longint req, input int s_in,
                        input int p_in, input int a_in, input bit poke,
                        input string tag);
    int e_sel, e_ph, e_aux, e_mis, e_err, n;
    longint e_freq;
    string ft;
    model(md, req, s_in, p_in, a_in, e_sel, e_ph, e_aux, e_freq, e_mis, e_err);
    @(negedge clk);
    mode_i = md; req_khz_i = 32'(req); set_divsel_i = 7'(s_in);
    set_phinc_i = 6'(p_in); set_aux_i = 1'(a_in); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_khz_i = 32'd148500; mode_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 1000) begin @(negedge clk); n++; end
    check(done_o == 1'b1, "R9", "done seen", done_o, 1);
    ft = md ? "R8" : "R7";
    check(range_err_o == 1'(e_err), e_err ? "R5" : tag, "range_err", range_err_o, e_err);
    check(divsel_o == 7'(e_sel), md ? "R8" : "R2", "divsel", divsel_o, e_sel);
    check(phinc_o == 6'(e_ph), md ? "R8" : "R2", "phinc", phinc_o, e_ph);
    check(aux_o == 1'(e_aux), tag, "aux", aux_o, e_aux);
    check(phdir_o == 1'b0, "R6", "phdir", phdir_o, 0);
    check(freq_khz_o == 32'(e_freq), ft, "freq", freq_khz_o, e_freq);
    check(mismatch_o == 1'(e_mis), ft, "mismatch", mismatch_o, e_mis);
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R9", "done dropped", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done_o == 0 && busy_o == 0, "R1", "done/busy in reset", {done_o, busy_o}, 0);
    check({divsel_o, phinc_o, aux_o, freq_khz_o, mismatch_o, range_err_o} == '0,
          "R1", "outputs in reset", freq_khz_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 0 && busy_o == 0 && freq_khz_o == 0, "R1", "idle after reset",
          freq_khz_o, 0);
    run_op(0, 148500, 0, 0, 0, 0, "R3");   // R2 R3 R7: mismatching request
    run_op(0, 27000, 0, 0, 0, 0, "R3");    // R3: exact at aux 0
    run_op(0, 25175, 0, 0, 0, 0, "R3");
    run_op(0, 21000, 0, 0, 0, 0, "R3");    // R3: select 126 fits
    run_op(0, 20700, 0, 0, 0, 0, "R4");    // R4: select 128, retried
    run_op(0, 20000, 0, 0, 0, 0, "R4");    // R4: near 20 MHz, exact
    run_op(0, 1500000, 0, 0, 0, 0, "R5");  // R5: divisor too small twice
    run_op(0, 10000, 0, 0, 0, 0, "R5");    // R5: too large even halved
    run_op(0, 0, 0, 0, 0, 0, "R5");        // R5: zero request
    run_op(0, 65000, 0, 0, 0, 0, "R3");    // recovery after errors
    run_op(1, 0, 127, 63, 1, 0, "R8");     // R8: largest fields
    run_op(1, 0, 0, 0, 0, 0, "R8");        // R8: smallest divisor
    run_op(1, 12345, 16, 12, 0, 0, "R8");
    run_op(0, 27000, 0, 0, 0, 1, "R3");    // R9: start while busy ignored
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule